// File: doc/BRIEF.md
# ADC Conversion Scan Sequencer

This block drives an 8-bit successive-approximation converter across four analog inputs. It picks the channel, pulses a one-cycle convert request, and waits for the converter's done strobe. It then stores the returned sample in one of four result slots. Three operating modes are supported: continuous scan over a channel mask, continuous interleaving of two chosen channels, and single-step. In single-step mode the block converts one channel per start event.

A conversion run begins on a start event from one selectable source: a software start strobe, a timer overflow pulse, or an edge on an external pin. The pin is synchronised and detected on a rising or a falling edge, as configured. A start event that arrives while a conversion is in flight is dropped, not queued. A sticky completion interrupt reports finished passes. A stop strobe lets the block run down to idle.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `busy`, `running`, `irq` and `conv_req` are low and all four result slots read zero.
- R2: With `cfg_mode` = 0 (scan), the channels set in `cfg_mask` are converted in ascending index order. After the highest set channel, the scan wraps to the lowest and continues without any further start event.
- R3: Each completed conversion writes its sample into the slot after the previous one (0,1,2,3,0,...). A run started from idle begins at slot 0. Slot s occupies `res_bus[8*s+7:8*s]`.
- R4: With `cfg_mode` = 1 (pair), the block converts `cfg_pair_a`, `cfg_pair_b`, `cfg_pair_a`, `cfg_pair_b` into slots 0, 1, 2 and 3, and repeats this group continuously.
- R5: `irq` is set only when `cfg_irq_en` is 1, and only at these points: after the highest selected channel in scan mode, after the slot-3 conversion in pair mode, and after every conversion in single-step mode. Once set, it stays high until a pulse on `irq_clr`.
- R6: With `cfg_mode` = 2 or 3 (single-step), the block converts one selected channel per start event. It then waits with `running` high and `busy` low. The next start event converts the next selected channel into the next slot.
- R7: `cfg_src` chooses the only source of start events: 0 = `sw_start`, 1 = `tmr_ovf`, 2 = pin edge, 3 = none. Strobes on sources that are not selected have no effect.
- R8: A start event that arrives while a conversion is requested or in progress is ignored. It does not cause an extra conversion later.
- R9: `ext_start_pin` passes through a two-flop synchroniser. With `cfg_edge_fall` = 0 only a rising edge starts a conversion; with 1 only a falling edge does.
- R10: A `stop_req` pulse during a conversion lets that conversion finish and store its result, after which the block goes idle. A pulse while waiting in single-step mode returns the block to idle at once.
- R11: In scan and single-step modes with `cfg_mask` = 0, start events are ignored and the block stays idle.
- R12: `conv_req` is high for exactly one cycle per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | 0 scan, 1 pair, 2/3 single-step |
| cfg_mask | input | 4 | Channels taking part in scan and single-step |
| cfg_pair_a | input | 2 | First channel of pair mode |
| cfg_pair_b | input | 2 | Second channel of pair mode |
| cfg_src | input | 2 | Start source: 0 software, 1 timer, 2 pin edge, 3 none |
| cfg_edge_fall | input | 1 | 1 selects a falling pin edge, 0 a rising one |
| cfg_irq_en | input | 1 | Allows the interrupt to be set |
| sw_start | input | 1 | Software start strobe |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_start_pin | input | 1 | Asynchronous external start pin |
| stop_req | input | 1 | Stop strobe |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| conv_req | output | 1 | One-cycle request to the converter |
| conv_chan | output | 2 | Channel being converted |
| conv_done | input | 1 | Converter finished strobe |
| conv_data | input | DATA_W | Converter sample |
| res_bus | output | 4*DATA_W | The four result slots, slot 0 in the low bits |
| busy | output | 1 | Conversion requested or in flight |
| running | output | 1 | Sequencer not idle |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The bench builds the block with its defaults: DATA_W = 8 and SYNC_STAGES = 2. A converter model answers each request three cycles later with a random sample. At this short latency, continuous runs wrap the four slots several times in a few dozen cycles, and the scan order can be compared against masks that have one, some or all channels set. The two-stage synchroniser keeps pin-edge starts within a handful of cycles. That lets the bench fire a trigger inside the three-cycle conversion window and show that it is lost.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  localparam int CH_N   = 4;
  localparam int CH_W   = $clog2(CH_N);
  localparam int SLOT_N = 4;
  localparam int SLOT_W = $clog2(SLOT_N);

  typedef enum logic [1:0] {
    MODE_SCAN     = 2'd0,
    MODE_PAIR     = 2'd1,
    MODE_STEP     = 2'd2,
    MODE_STEP_ALT = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SRC_SW  = 2'd0,
    SRC_TMR = 2'd1,
    SRC_PIN = 2'd2,
    SRC_OFF = 2'd3
  } src_e;

  // Next set bit of mask strictly after cur, wrapping; cur if mask is empty.
  function automatic logic [CH_W-1:0] next_sel(input logic [CH_N-1:0] mask,
                                               input logic [CH_W-1:0] cur);
    logic [CH_W-1:0] pick;
    logic            hit;
    int              idx;
    pick = cur;
    hit  = 1'b0;
    for (int k = 1; k <= CH_N; k++) begin
      idx = (int'(cur) + k) % CH_N;
      if (!hit && mask[idx[CH_W-1:0]]) begin
        pick = idx[CH_W-1:0];
        hit  = 1'b1;
      end
    end
    return pick;
  endfunction

  // Lowest selected channel.
  function automatic logic [CH_W-1:0] first_sel(input logic [CH_N-1:0] mask);
    return next_sel(mask, CH_W'(CH_N - 1));
  endfunction

  // Highest selected channel: the end of one scan pass.
  function automatic logic [CH_W-1:0] last_sel(input logic [CH_N-1:0] mask);
    logic [CH_W-1:0] pick;
    pick = '0;
    for (int k = 0; k < CH_N; k++) begin
      if (mask[k]) pick = CH_W'(k);
    end
    return pick;
  endfunction

  function automatic logic [SLOT_W-1:0] slot_after(input logic [SLOT_W-1:0] s);
    return SLOT_W'(s + 1'b1);
  endfunction

endpackage

// File: rtl/adcseq_trigger.sv
module adcseq_trigger
  import adcseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src,
  input  logic       edge_fall,
  input  logic       sw_start,
  input  logic       tmr_ovf,
  input  logic       ext_pin,
  output logic       edge_evt,
  output logic       start_evt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_prev_q;
  logic                   lvl;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ext_pin;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_pin};
      end
    end
  endgenerate

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev_q <= 1'b0;
    else        lvl_prev_q <= lvl;
  end

  assign edge_evt = edge_fall ? (lvl_prev_q & ~lvl) : (~lvl_prev_q & lvl);

  always_comb begin
    unique case (src_e'(src))
      SRC_SW:  start_evt = sw_start;
      SRC_TMR: start_evt = tmr_ovf;
      SRC_PIN: start_evt = edge_evt;
      default: start_evt = 1'b0;
    endcase
  end

  assert_src_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'd3) |-> !start_evt);

  assert_tmr_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && src == 2'd1) |-> tmr_ovf);

  assert_edge_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && !edge_fall) |=> lvl_prev_q);

endmodule

// File: rtl/adcseq_results.sv
module adcseq_results #(
  parameter int DATA_W = 8,
  parameter int SLOT_N = 4,
  parameter int SLOT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SLOT_W-1:0]        wr_slot,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [SLOT_N*DATA_W-1:0] res_bus
);

  logic [SLOT_N-1:0] slot_we;

  generate
    for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
      logic [DATA_W-1:0] val_q;
      assign slot_we[g] = wr_en && (wr_slot == SLOT_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          val_q <= '0;
        else if (slot_we[g]) val_q <= wr_data;
      end
      assign res_bus[g*DATA_W +: DATA_W] = val_q;
    end
  endgenerate

  assert_one_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we));

  assert_write_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(slot_we) == 1));

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [CH_N-1:0]   mask,
  input  logic [CH_W-1:0]   pair_a,
  input  logic [CH_W-1:0]   pair_b,
  input  logic              irq_en,
  input  logic              start_evt,
  input  logic              stop_req,
  input  logic              irq_clr,
  input  logic              conv_done,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_chan,
  output logic              busy,
  output logic              running,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic              irq
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_REQ, ST_CONV} st_e;

  st_e               st_q;
  logic [CH_W-1:0]   chan_q;
  logic [SLOT_W-1:0] slot_q;
  logic              stop_pend_q;
  logic              irq_q;

  logic              is_pair, is_step, mask_ok, launch, take_done;
  logic              pass_end, irq_hit, end_run;
  logic [CH_W-1:0]   first_ch, next_ch;
  logic [SLOT_W-1:0] next_slot;

  always_comb begin
    is_pair   = (mode_e'(mode) == MODE_PAIR);
    is_step   = (mode_e'(mode) == MODE_STEP) || (mode_e'(mode) == MODE_STEP_ALT);
    mask_ok   = is_pair || (mask != '0);
    first_ch  = is_pair ? pair_a : first_sel(mask);
    next_slot = slot_after(slot_q);
    next_ch   = is_pair ? (next_slot[0] ? pair_b : pair_a) : next_sel(mask, chan_q);
    launch    = (st_q == ST_IDLE) && start_evt && mask_ok;
    take_done = (st_q == ST_CONV) && conv_done;
    end_run   = stop_pend_q || stop_req;
    pass_end  = is_step ||
                (is_pair ? (slot_q == SLOT_W'(SLOT_N - 1)) : (chan_q == last_sel(mask)));
    irq_hit   = take_done && irq_en && pass_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      chan_q      <= '0;
      slot_q      <= '0;
      stop_pend_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      if (irq_hit)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;

      case (st_q)
        ST_IDLE: begin
          stop_pend_q <= 1'b0;
          if (launch) begin
            chan_q <= first_ch;
            slot_q <= '0;
            st_q   <= ST_REQ;
          end
        end
        ST_WAIT: begin
          if (stop_req)       st_q <= ST_IDLE;
          else if (start_evt) st_q <= ST_REQ;
        end
        ST_REQ: begin
          st_q <= ST_CONV;
          if (stop_req) stop_pend_q <= 1'b1;
        end
        ST_CONV: begin
          if (conv_done) begin
            chan_q      <= next_ch;
            slot_q      <= next_slot;
            stop_pend_q <= 1'b0;
            if (end_run)      st_q <= ST_IDLE;
            else if (is_step) st_q <= ST_WAIT;
            else              st_q <= ST_REQ;
          end else if (stop_req) begin
            stop_pend_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_req  = (st_q == ST_REQ);
  assign conv_chan = chan_q;
  assign busy      = (st_q == ST_REQ) || (st_q == ST_CONV);
  assign running   = (st_q != ST_IDLE);
  assign wr_en     = take_done;
  assign wr_slot   = slot_q;
  assign irq       = irq_q;

  assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  assert_trigger_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_evt && !conv_done) |=> !conv_req);

  assert_empty_mask_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !is_pair && mask == '0) |=> !running);

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_step_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !busy && !start_evt) |=> !conv_req);

  assert_slot_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_slot == SLOT_W'($past(wr_slot) + 1'b1)));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adcseq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cfg_mode,
  input  logic [3:0]               cfg_mask,
  input  logic [1:0]               cfg_pair_a,
  input  logic [1:0]               cfg_pair_b,
  input  logic [1:0]               cfg_src,
  input  logic                     cfg_edge_fall,
  input  logic                     cfg_irq_en,
  input  logic                     sw_start,
  input  logic                     tmr_ovf,
  input  logic                     ext_start_pin,
  input  logic                     stop_req,
  input  logic                     irq_clr,
  output logic                     conv_req,
  output logic [1:0]               conv_chan,
  input  logic                     conv_done,
  input  logic [DATA_W-1:0]        conv_data,
  output logic [4*DATA_W-1:0]      res_bus,
  output logic                     busy,
  output logic                     running,
  output logic                     irq
);

  logic              start_evt;
  logic              edge_evt;
  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;

  adcseq_trigger #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (cfg_src),
    .edge_fall (cfg_edge_fall),
    .sw_start  (sw_start),
    .tmr_ovf   (tmr_ovf),
    .ext_pin   (ext_start_pin),
    .edge_evt  (edge_evt),
    .start_evt (start_evt)
  );

  adcseq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (cfg_mode),
    .mask      (cfg_mask),
    .pair_a    (cfg_pair_a),
    .pair_b    (cfg_pair_b),
    .irq_en    (cfg_irq_en),
    .start_evt (start_evt),
    .stop_req  (stop_req),
    .irq_clr   (irq_clr),
    .conv_done (conv_done),
    .conv_req  (conv_req),
    .conv_chan (conv_chan),
    .busy      (busy),
    .running   (running),
    .wr_en     (wr_en),
    .wr_slot   (wr_slot),
    .irq       (irq)
  );

  adcseq_results #(.DATA_W(DATA_W), .SLOT_N(SLOT_N), .SLOT_W(SLOT_W)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_data (conv_data),
    .res_bus (res_bus)
  );

  assert_edge_only_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_src == 2'd2 && start_evt) |-> edge_evt);

endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;

  localparam int DW  = 8;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [1:0]    cfg_mode, cfg_pair_a, cfg_pair_b, cfg_src;
  logic [3:0]    cfg_mask;
  logic          cfg_edge_fall, cfg_irq_en;
  logic          sw_start, tmr_ovf, ext_start_pin, stop_req, irq_clr;
  logic          conv_done;
  logic [DW-1:0] conv_data;
  logic          conv_req, busy, running, irq;
  logic [1:0]    conv_chan;
  logic [4*DW-1:0] res_bus;

  adc_scan_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_mask(cfg_mask),
    .cfg_pair_a(cfg_pair_a), .cfg_pair_b(cfg_pair_b), .cfg_src(cfg_src),
    .cfg_edge_fall(cfg_edge_fall), .cfg_irq_en(cfg_irq_en), .sw_start(sw_start),
    .tmr_ovf(tmr_ovf), .ext_start_pin(ext_start_pin), .stop_req(stop_req),
    .irq_clr(irq_clr), .conv_req(conv_req), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data), .res_bus(res_bus),
    .busy(busy), .running(running), .irq(irq)
  );

  int          checks = 0;
  int          fails = 0;
  int          conv_cnt = 0;
  bit          finished = 0;
  bit          ref_fresh = 1;
  logic [1:0]  ref_chan = 0;
  logic [1:0]  ref_slot = 0;
  bit          exp_irq = 0;
  logic [DW-1:0] exp_res [4];

  function automatic logic [1:0] b_first(input logic [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) return 2'(i);
    return 2'd0;
  endfunction

  function automatic logic [1:0] b_last(input logic [3:0] m);
    for (int i = 3; i >= 0; i--) if (m[i]) return 2'(i);
    return 2'd0;
  endfunction

  function automatic logic [1:0] b_next(input logic [3:0] m, input logic [1:0] c);
    for (int d = 1; d <= 4; d++) begin
      if (m[(int'(c) + d) & 3]) return 2'((int'(c) + d) & 3);
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_sw();   @(negedge clk); sw_start = 1; @(negedge clk); sw_start = 0; endtask
  task automatic pulse_tmr();  @(negedge clk); tmr_ovf  = 1; @(negedge clk); tmr_ovf  = 0; endtask
  task automatic pulse_stop(); @(negedge clk); stop_req = 1; @(negedge clk); stop_req = 0; endtask
  task automatic pulse_clr();  @(negedge clk); irq_clr  = 1; @(negedge clk); irq_clr  = 0; endtask

  task automatic wait_cnt(input int target, input int lim, input string tag);
    int k;
    k = 0;
    while (conv_cnt < target && k < lim) begin
      @(negedge clk);
      k++;
    end
    if (conv_cnt < target) chk(1'b0, tag, conv_cnt, target);
  endtask

  // Converter model plus reference sequence checker
  initial begin
    logic [1:0]    ec, es;
    logic [DW-1:0] d;
    bit            hit;
    conv_done = 0;
    conv_data = '0;
    forever begin
      if (rst_n === 1'b1 && conv_req === 1'b1) begin
        if (ref_fresh) begin
          es = 2'd0;
          ec = (cfg_mode == 2'd1) ? cfg_pair_a : b_first(cfg_mask);
        end else begin
          es = ref_slot + 2'd1;
          ec = (cfg_mode == 2'd1) ? (es[0] ? cfg_pair_b : cfg_pair_a) : b_next(cfg_mask, ref_chan);
        end
        ref_fresh = 0;
        ref_chan  = ec;
        ref_slot  = es;
        chk(conv_chan == ec, "R2 R4 channel order", conv_chan, ec);
        @(negedge clk);
        chk(!conv_req, "R12 request one cycle", conv_req, 0);
        repeat (LAT - 2) @(negedge clk);
        d = DW'($urandom_range(0, 255));
        conv_data = d;
        conv_done = 1;
        @(negedge clk);
        conv_done = 0;
        exp_res[es] = d;
        hit = cfg_irq_en && (cfg_mode >= 2'd2 ||
              (cfg_mode == 2'd1 ? (es == 2'd3) : (ec == b_last(cfg_mask))));
        if (hit) exp_irq = 1;
        chk(res_bus[es*DW +: DW] == d, "R3 slot written", res_bus[es*DW +: DW], d);
        chk(irq == exp_irq, "R5 irq point", irq, exp_irq);
        conv_cnt++;
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic run_cont(input logic [1:0] md, input logic [3:0] m,
                          input logic [1:0] a, input logic [1:0] b,
                          input bit ien, input int n);
    int base;
    cfg_mode = md; cfg_mask = m; cfg_pair_a = a; cfg_pair_b = b;
    cfg_src = 2'd0; cfg_irq_en = ien;
    pulse_clr();
    exp_irq = 0;
    ref_fresh = 1;
    base = conv_cnt;
    pulse_sw();
    wait_cnt(base + n, 400, "R2 R4 continuous progress");
    pulse_stop();
    repeat (20) @(negedge clk);
    chk(conv_cnt == base + n + 1, "R10 stop after current", conv_cnt, base + n + 1);
    chk(!running, "R10 idle after stop", running, 0);
    for (int s = 0; s < 4; s++)
      chk(res_bus[s*DW +: DW] == exp_res[s], "R3 slot contents", res_bus[s*DW +: DW], exp_res[s]);
    chk(irq == exp_irq, "R5 irq after run", irq, exp_irq);
    pulse_clr();
    @(negedge clk);
    chk(!irq, "R5 irq cleared", irq, 0);
  endtask

  initial begin
    int         base;
    logic [3:0] m;
    logic [1:0] a, b;
    void'($urandom(32'h5EED0A11));
    rst_n = 0;
    cfg_mode = 0; cfg_mask = 0; cfg_pair_a = 0; cfg_pair_b = 0; cfg_src = 0;
    cfg_edge_fall = 0; cfg_irq_en = 0;
    sw_start = 0; tmr_ovf = 0; ext_start_pin = 0; stop_req = 0; irq_clr = 0;
    for (int s = 0; s < 4; s++) exp_res[s] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !running, "R1 reset idle", {busy, running}, 0);
    chk(!irq, "R1 reset irq", irq, 0);
    chk(!conv_req, "R1 reset request", conv_req, 0);
    chk(res_bus == '0, "R1 reset slots", 0, 0);

    // R2 R3 scan: all channels, one channel, random masks
    run_cont(2'd0, 4'b1111, 2'd0, 2'd0, 1, 9);
    run_cont(2'd0, 4'b1000, 2'd0, 2'd0, 1, 6);
    for (int r = 0; r < 3; r++) begin
      m = 4'($urandom_range(1, 15));
      run_cont(2'd0, m, 2'd0, 2'd0, 1, 7 + r);
    end

    // R4 pair mode, with and without interrupt enable
    for (int r = 0; r < 3; r++) begin
      a = 2'($urandom_range(0, 3));
      b = 2'($urandom_range(0, 3));
      run_cont(2'd1, 4'($urandom_range(0, 15)), a, b, r != 1, 9);
    end

    // R6 R8 single-step with timer starts
    cfg_mode = 2'd2; cfg_src = 2'd1; cfg_irq_en = 1;
    cfg_mask = 4'($urandom_range(1, 15)) | 4'b0100;
    pulse_clr(); exp_irq = 0; ref_fresh = 1;
    for (int k = 0; k < 5; k++) begin
      base = conv_cnt;
      @(negedge clk); tmr_ovf = 1;
      @(negedge clk); tmr_ovf = 0;
      @(negedge clk); tmr_ovf = 1;   // lands inside the conversion
      @(negedge clk); tmr_ovf = 0;
      wait_cnt(base + 1, 50, "R6 step conversion");
      repeat (15) @(negedge clk);
      chk(conv_cnt == base + 1, "R8 trigger during conversion dropped", conv_cnt, base + 1);
      chk(running && !busy, "R6 waiting for start", {running, busy}, 2);
      chk(irq, "R5 irq per step", irq, 1);
      pulse_clr(); exp_irq = 0;
    end
    // R7 software strobe ignored under timer source
    base = conv_cnt;
    pulse_sw();
    repeat (10) @(negedge clk);
    chk(conv_cnt == base, "R7 unselected source ignored", conv_cnt, base);
    pulse_stop();
    @(negedge clk);
    chk(!running, "R10 stop while waiting", running, 0);

    // R9 falling-edge starts in single-step
    cfg_edge_fall = 1;
    ext_start_pin = 1;
    repeat (6) @(negedge clk);
    cfg_src = 2'd2; ref_fresh = 1;
    base = conv_cnt;
    ext_start_pin = 0;
    wait_cnt(base + 1, 30, "R9 falling edge starts");
    repeat (5) @(negedge clk);
    ext_start_pin = 1;
    repeat (15) @(negedge clk);
    chk(conv_cnt == base + 1, "R9 rising ignored when falling chosen", conv_cnt, base + 1);
    ext_start_pin = 0;
    wait_cnt(base + 2, 30, "R9 second falling edge");
    repeat (4) @(negedge clk);
    pulse_stop();
    repeat (4) @(negedge clk);
    chk(!running, "R10 idle after edge run", running, 0);

    // R9 rising edge starts a continuous scan
    cfg_edge_fall = 0; cfg_mode = 2'd0; cfg_mask = 4'b0110;
    pulse_clr(); exp_irq = 0; ref_fresh = 1;
    base = conv_cnt;
    ext_start_pin = 1;
    wait_cnt(base + 4, 100, "R9 rising edge starts scan");
    pulse_stop();
    repeat (20) @(negedge clk);
    chk(conv_cnt == base + 5, "R10 scan stop after current", conv_cnt, base + 5);
    ext_start_pin = 0;
    repeat (6) @(negedge clk);

    // R11 empty mask
    cfg_src = 2'd0; cfg_mask = 4'b0000;
    for (int md = 0; md < 4; md += 2) begin
      cfg_mode = 2'(md);
      base = conv_cnt;
      pulse_sw();
      repeat (10) @(negedge clk);
      chk(!running && conv_cnt == base, "R11 empty mask ignored", conv_cnt, base);
    end

    // R7 source off
    cfg_mode = 2'd0; cfg_mask = 4'b1111; cfg_src = 2'd3;
    base = conv_cnt;
    pulse_sw(); pulse_tmr();
    ext_start_pin = 1; repeat (6) @(negedge clk);
    ext_start_pin = 0; repeat (6) @(negedge clk);
    chk(!running && conv_cnt == base, "R7 no source selected", conv_cnt, base);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog R2: actual %0d conversions expected run to end", conv_cnt);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule